// File: doc/BRIEF.md
# Inbound Message Post Queue Controller

This block receives message words that bus-side agents write to a single queue port and places them in a circular queue kept in local memory. Each accepted word goes out through a memory write request/acknowledge interface to the slot that the hardware-owned head pointer selects. The head moves forward only once memory has acknowledged the store. The local processor owns the tail pointer. After it has read the message at the tail slot, it advances the tail with a one-cycle pulse.

The bus side gets an accept or retry answer in the same cycle as the write. Writes are retried while a store is outstanding and while the queue is full. The queue is full when a head advance lands on the tail. Two actions release the full state: a tail advance, or clearing the interrupt status bit. Every completed post sets a status bit. That bit is cleared by writing 1 on a clear strobe. The interrupt output is the status bit gated by a mask bit, and the mask bit is set at reset.

Top module: `msg_post_queue`

## Requirements
- R1: An accepted word is written to memory at address BASE_ADDR + 4*head_index, with the same data word. The head_addr output shows that address.
- R2: mem_req stays high with mem_addr and mem_data unchanged until a one-cycle mem_ack. On the clock edge of that ack the head advances by one 4-byte slot, and it wraps to BASE_ADDR after 2**DEPTH_LOG2 slots. At no other time does the head move.
- R3: For a write presented on port_wr_valid, exactly one of port_accept and port_retry is high in that same cycle. Every write presented while a store is outstanding is retried. The outstanding period runs from the cycle after acceptance through the ack cycle.
- R4: Each tail_inc pulse advances tail_addr by one 4-byte slot, with the same wrap. The word at the old tail slot is the one that was posted there.
- R5: A completed store sets irq_status on the ack edge. irq_out is high exactly when irq_status is 1 and irq_mask is 0.
- R6: An irq_clr pulse clears irq_status and drops irq_out. If a store completes in the same cycle, the set wins.
- R7: q_full rises when a head advance makes the head equal to the tail. While q_full is 1, every port write is retried.
- R8: While full, a tail_inc pulse or an irq_clr pulse clears q_full, and the next port write is accepted.
- R9: After reset, head_addr = tail_addr = BASE_ADDR, q_full = 0, irq_status = 0, irq_mask = 1, irq_out = 0 and mem_req = 0.
- R10: A mask_wr_en pulse loads mask_wr_val into irq_mask on the next edge.
- R11: When a tail_inc falls in the ack cycle of a store, both pointers advance. Fullness is then judged on the new values, so the queue does not go full even if the old tail equalled the new head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_wr_valid | input | 1 | Bus write presented to the queue port |
| port_wr_data | input | DATA_W | Message word of that write |
| port_accept | output | 1 | Write taken this cycle |
| port_retry | output | 1 | Write refused this cycle, to be retried |
| mem_req | output | 1 | Memory store request |
| mem_addr | output | ADDR_W | Store byte address |
| mem_data | output | DATA_W | Store data |
| mem_ack | input | 1 | One-cycle store acknowledge |
| tail_inc | input | 1 | Processor advance of the tail pointer |
| irq_clr | input | 1 | Write-1 clear of the status bit |
| mask_wr_en | input | 1 | Load enable for the mask bit |
| mask_wr_val | input | 1 | New mask value |
| head_addr | output | ADDR_W | Byte address of the head slot |
| tail_addr | output | ADDR_W | Byte address of the tail slot |
| q_full | output | 1 | Queue full flag |
| irq_status | output | 1 | Post status bit |
| irq_mask | output | 1 | Interrupt mask bit |
| irq_out | output | 1 | Processor interrupt |

## Verification
port_accept and port_retry are combinational on the presented write, so they are sampled 1 ns after the bench drives the write on a falling edge. mem_req rises on the first edge after acceptance. The head, irq_status and q_full all change on the edge that carries mem_ack, so the bench waits for the scoreboard to retire the item, lets one more rising edge pass, and samples on the next falling edge. Pulses on tail_inc, irq_clr and mask_wr_en last one cycle, and their effects are read at the falling edge after the following rising edge. The memory model varies its acknowledge latency, and it can raise tail_inc in the exact ack cycle to exercise the same-cycle pointer case.

// File: rtl/mpq_pkg.sv
package mpq_pkg;

  // Advance a ring index by one, wrapping at 2**log2_depth entries.
  function automatic logic [31:0] ring_next(input logic [31:0] idx,
                                            input int unsigned log2_depth);
    logic [31:0] lim;
    lim = (32'd1 << log2_depth) - 32'd1;
    return (idx + 32'd1) & lim;
  endfunction

  // Byte address of a slot: base plus index scaled by the word size.
  function automatic logic [31:0] slot_addr(input logic [31:0] base,
                                            input logic [31:0] idx,
                                            input int unsigned log2_word);
    return base + (idx << log2_word);
  endfunction

endpackage

// File: rtl/mpq_ptr_track.sv
module mpq_ptr_track #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             head_step,
  input  logic             tail_step,
  input  logic             full_drop,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic             full,
  output logic             lands_on_tail
);
  logic [IDX_W-1:0] head_nx, tail_nx;

  always_comb begin
    head_nx = head_step ? IDX_W'(mpq_pkg::ring_next(32'(head_idx), IDX_W)) : head_idx;
    tail_nx = tail_step ? IDX_W'(mpq_pkg::ring_next(32'(tail_idx), IDX_W)) : tail_idx;
  end

  // Fullness is judged on the updated pointers.
  assign lands_on_tail = head_step && (head_nx == tail_nx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_idx <= '0;
      tail_idx <= '0;
      full     <= 1'b0;
    end else begin
      head_idx <= head_nx;
      tail_idx <= tail_nx;
      if (lands_on_tail)
        full <= 1'b1;
      else if (tail_step || full_drop)
        full <= 1'b0;
    end
  end
endmodule

// File: rtl/mpq_store_ctl.sv
module mpq_store_ctl #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ADDR_W-1:0] take_addr,
  input  logic [DATA_W-1:0] take_data,
  input  logic              mem_ack,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              busy,
  output logic              store_done
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req  <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
    end else if (take) begin
      mem_req  <= 1'b1;
      mem_addr <= take_addr;
      mem_data <= take_data;
    end else if (mem_req && mem_ack) begin
      mem_req  <= 1'b0;
    end
  end

  assign busy       = mem_req;
  assign store_done = mem_req && mem_ack;
endmodule

// File: rtl/mpq_irq_reg.sv
module mpq_irq_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic post,
  input  logic clr,
  input  logic mask_we,
  input  logic mask_val,
  output logic status,
  output logic mask,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= 1'b0;
      mask   <= 1'b1;
    end else begin
      if (post)
        status <= 1'b1;
      else if (clr)
        status <= 1'b0;
      if (mask_we)
        mask <= mask_val;
    end
  end

  assign irq = status & ~mask;
endmodule

// File: rtl/msg_post_queue.sv
module msg_post_queue #(
  parameter int              ADDR_W     = 32,
  parameter int              DATA_W     = 32,
  parameter int              DEPTH_LOG2 = 4,
  parameter int              WORD_LOG2  = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_wr_valid,
  input  logic [DATA_W-1:0] port_wr_data,
  output logic              port_accept,
  output logic              port_retry,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  input  logic              mem_ack,
  input  logic              tail_inc,
  input  logic              irq_clr,
  input  logic              mask_wr_en,
  input  logic              mask_wr_val,
  output logic [ADDR_W-1:0] head_addr,
  output logic [ADDR_W-1:0] tail_addr,
  output logic              q_full,
  output logic              irq_status,
  output logic              irq_mask,
  output logic              irq_out
);
  localparam int IDX_W = DEPTH_LOG2;

  logic [IDX_W-1:0] head_idx, tail_idx;
  logic             store_busy, store_done, post_take, lands_on_tail;

  // Same-cycle answer to the port.
  assign post_take   = port_wr_valid && !store_busy && !q_full;
  assign port_accept = post_take;
  assign port_retry  = port_wr_valid && (store_busy || q_full);

  assign head_addr = ADDR_W'(mpq_pkg::slot_addr(32'(BASE_ADDR), 32'(head_idx), WORD_LOG2));
  assign tail_addr = ADDR_W'(mpq_pkg::slot_addr(32'(BASE_ADDR), 32'(tail_idx), WORD_LOG2));

  mpq_store_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (post_take),
    .take_addr  (head_addr),
    .take_data  (port_wr_data),
    .mem_ack    (mem_ack),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_data   (mem_data),
    .busy       (store_busy),
    .store_done (store_done)
  );

  mpq_ptr_track #(.IDX_W(IDX_W)) u_ptr (
    .clk           (clk),
    .rst_n         (rst_n),
    .head_step     (store_done),
    .tail_step     (tail_inc),
    .full_drop     (irq_clr),
    .head_idx      (head_idx),
    .tail_idx      (tail_idx),
    .full          (q_full),
    .lands_on_tail (lands_on_tail)
  );

  mpq_irq_reg u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .post     (store_done),
    .clr      (irq_clr),
    .mask_we  (mask_wr_en),
    .mask_val (mask_wr_val),
    .status   (irq_status),
    .mask     (irq_mask),
    .irq      (irq_out)
  );
endmodule

// File: rtl/mpq_checker.sv
module mpq_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              port_wr_valid,
  input logic              port_accept,
  input logic              port_retry,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_data,
  input logic              mem_ack,
  input logic              tail_inc,
  input logic              irq_clr,
  input logic              mask_wr_en,
  input logic              mask_wr_val,
  input logic [ADDR_W-1:0] head_addr,
  input logic              q_full,
  input logic              irq_status,
  input logic              irq_mask,
  input logic              store_done,
  input logic              post_take
);
  a_r1_take_starts_store: assert property (@(posedge clk) disable iff (!rst_n)
    post_take |=> mem_req);
  a_r1_store_at_head: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr == head_addr));
  a_r2_request_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_data)));
  a_r2_head_moves_on_ack_only: assert property (@(posedge clk) disable iff (!rst_n)
    !store_done |=> $stable(head_addr));
  a_r3_single_answer: assert property (@(posedge clk) disable iff (!rst_n)
    port_wr_valid |-> (port_accept != port_retry));
  a_r3_retry_while_storing: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && port_wr_valid) |-> (port_retry && !port_accept));
  a_r5_post_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    store_done |=> irq_status);
  a_r6_clear_drops_status: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !store_done) |=> !irq_status);
  a_r7_full_retries: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && port_wr_valid) |-> (port_retry && !port_accept));
  a_r8_full_released: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && (tail_inc || irq_clr) && !store_done) |=> !q_full);
  a_r10_mask_loads: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr_en |=> (irq_mask == $past(mask_wr_val)));
endmodule

bind msg_post_queue mpq_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .port_wr_valid (port_wr_valid),
  .port_accept   (port_accept),
  .port_retry    (port_retry),
  .mem_req       (mem_req),
  .mem_addr      (mem_addr),
  .mem_data      (mem_data),
  .mem_ack       (mem_ack),
  .tail_inc      (tail_inc),
  .irq_clr       (irq_clr),
  .mask_wr_en    (mask_wr_en),
  .mask_wr_val   (mask_wr_val),
  .head_addr     (head_addr),
  .q_full        (q_full),
  .irq_status    (irq_status),
  .irq_mask      (irq_mask),
  .store_done    (store_done),
  .post_take     (post_take)
);

// File: tb/sim_msg_post_queue.sv
`timescale 1ns/1ps
module sim_msg_post_queue;
  localparam int          DEPTH = 16;
  localparam logic [31:0] BASE  = 32'h4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic port_wr_valid = 1'b0;
  logic [31:0] port_wr_data = '0;
  logic port_accept, port_retry, mem_req, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_data, head_addr, tail_addr;
  logic tinc_drv = 1'b0, tinc_mem = 1'b0;
  logic tail_inc;
  logic irq_clr = 1'b0, mask_wr_en = 1'b0, mask_wr_val = 1'b0;
  logic q_full, irq_status, irq_mask, irq_out;

  assign tail_inc = tinc_drv | tinc_mem;

  always #2 clk = ~clk;

  msg_post_queue u0 (
    .clk(clk), .rst_n(rst_n),
    .port_wr_valid(port_wr_valid), .port_wr_data(port_wr_data),
    .port_accept(port_accept), .port_retry(port_retry),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data), .mem_ack(mem_ack),
    .tail_inc(tail_inc), .irq_clr(irq_clr),
    .mask_wr_en(mask_wr_en), .mask_wr_val(mask_wr_val),
    .head_addr(head_addr), .tail_addr(tail_addr), .q_full(q_full),
    .irq_status(irq_status), .irq_mask(irq_mask), .irq_out(irq_out)
  );

  typedef struct { logic [31:0] a; logic [31:0] d; } item_t;
  item_t       exp_q[$];
  logic [31:0] mem_model [DEPTH];
  logic [31:0] exp_slot  [DEPTH];
  int total = 0, bad = 0;
  int post_cnt = 0, done_cnt = 0, tcnt = 0, lat = 0;
  bit seen = 0, inc_on_ack = 0;
  logic [31:0] saved_a, saved_d;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] slot(input int n);
    return BASE + 32'((n % DEPTH) * 4);
  endfunction

  // Memory model and scoreboard monitor.
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 0; lat = 0; tinc_mem = 0; seen = 0;
    end else begin
      tinc_mem = 0;
      if (mem_req && !mem_ack) begin
        if (!seen) begin
          seen = 1; saved_a = mem_addr; saved_d = mem_data;
        end else if (mem_addr != saved_a || mem_data != saved_d) begin
          check(0, "R2 request changed before ack", mem_addr, saved_a);
        end
        if (lat >= (done_cnt % 3)) begin
          item_t it;
          mem_ack = 1; lat = 0; seen = 0;
          if (exp_q.size() == 0) begin
            check(0, "R1 store with no posted word", mem_addr, 32'h0);
          end else begin
            it = exp_q.pop_front();
            check(mem_addr == it.a, "R1 store address", mem_addr, it.a);
            check(mem_data == it.d, "R1 store data", mem_data, it.d);
          end
          mem_model[((mem_addr - BASE) >> 2) % DEPTH] = mem_data;
          done_cnt++;
          if (inc_on_ack) begin
            tinc_mem = 1; inc_on_ack = 0; tcnt++;
          end
        end else begin
          lat++;
        end
      end else begin
        mem_ack = 0;
      end
    end
  end

  // Driver: present a write until accepted, push the expected store.
  task automatic post(input logic [31:0] d, input bit probe);
    int tries = 0;
    item_t it;
    @(negedge clk);
    port_wr_valid = 1; port_wr_data = d;
    #1;
    while (!port_accept && tries < 200) begin
      @(negedge clk); #1; tries++;
    end
    check(port_accept && !port_retry, "R3 write accepted", {31'b0, port_accept}, 32'h1);
    it.a = slot(post_cnt); it.d = d;
    exp_q.push_back(it);
    exp_slot[post_cnt % DEPTH] = d;
    post_cnt++;
    @(negedge clk);
    if (probe) begin
      port_wr_data = ~d;
      #1;
      check(port_retry && !port_accept, "R3 retry while store outstanding", {31'b0, port_retry}, 32'h1);
    end
    port_wr_valid = 0;
  endtask

  task automatic wait_idle();
    while (done_cnt != post_cnt) @(negedge clk);
    @(negedge clk); #1;
  endtask

  task automatic expect_retry(input string tag);
    @(negedge clk);
    port_wr_valid = 1; port_wr_data = 32'hdead_0000;
    #1;
    check(port_retry && !port_accept, tag, {31'b0, port_retry}, 32'h1);
    port_wr_valid = 0;
  endtask

  task automatic tail_step();
    @(negedge clk); tinc_drv = 1; tcnt++;
    @(negedge clk); tinc_drv = 0; #1;
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0; #1;
  endtask

  task automatic set_mask(input logic v);
    @(negedge clk); mask_wr_en = 1; mask_wr_val = v;
    @(negedge clk); mask_wr_en = 0; #1;
  endtask

  task automatic check_ptrs(input string tag);
    check(head_addr == slot(post_cnt), {tag, " head"}, head_addr, slot(post_cnt));
    check(tail_addr == slot(tcnt), {tag, " tail"}, tail_addr, slot(tcnt));
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R9 reset state
    check(head_addr == BASE && tail_addr == BASE, "R9 pointers at base", head_addr, BASE);
    check(!q_full && !mem_req, "R9 not full, no request", {31'b0, q_full}, 32'h0);
    check(!irq_status && irq_mask && !irq_out, "R9 status clear, masked", {29'b0, irq_status, irq_mask, irq_out}, 32'h2);

    // R1/R2/R3/R5: three posts with probes
    post(32'h1111_0001, 1); wait_idle();
    check_ptrs("R2 after one post");
    post(32'h2222_0002, 1); post(32'h3333_0003, 1); wait_idle();
    check_ptrs("R2 after three posts");
    check(irq_status == 1, "R5 status set by post", {31'b0, irq_status}, 32'h1);
    check(irq_out == 0, "R5 masked interrupt low", {31'b0, irq_out}, 32'h0);
    set_mask(1'b0);
    check(irq_mask == 0, "R10 mask loaded", {31'b0, irq_mask}, 32'h0);
    check(irq_out == 1, "R5 unmasked interrupt high", {31'b0, irq_out}, 32'h1);
    clear_irq();
    check(!irq_status && !irq_out, "R6 clear drops status", {30'b0, irq_status, irq_out}, 32'h0);

    // R4: processor drains three words
    for (int i = 0; i < 3; i++) begin
      logic [31:0] idx;
      idx = ((tail_addr - BASE) >> 2) % DEPTH;
      check(mem_model[idx] == exp_slot[idx], "R4 word at tail slot", mem_model[idx], exp_slot[idx]);
      tail_step();
      check(tail_addr == slot(tcnt), "R4 tail advanced", tail_addr, slot(tcnt));
    end

    // R7: fill, head wraps and lands on tail
    for (int i = 0; i < DEPTH; i++) begin
      post(32'hA000_0000 + 32'(i), 0); wait_idle();
      if (i < DEPTH - 1)
        check(!q_full, "R7 not yet full", {31'b0, q_full}, 32'h0);
    end
    check_ptrs("R2 wrap after fill");
    check(q_full, "R7 full when head meets tail", {31'b0, q_full}, 32'h1);
    expect_retry("R7 retry while full");
    expect_retry("R7 retry while full again");

    // R8: release by tail advance
    tail_step();
    check(!q_full, "R8 tail advance releases full", {31'b0, q_full}, 32'h0);
    post(32'hB000_0001, 0); wait_idle();
    check(q_full, "R7 full again after one more post", {31'b0, q_full}, 32'h1);
    // R8: release by status clear
    clear_irq();
    check(!q_full && !irq_status, "R8 clear releases full", {30'b0, q_full, irq_status}, 32'h0);
    post(32'hB000_0002, 1); wait_idle();
    check_ptrs("R8 posting resumed");

    // R11: tail advance in the ack cycle
    inc_on_ack = 1;
    post(32'hC000_0001, 0); wait_idle();
    check_ptrs("R11 both advanced");
    for (int i = 0; i < DEPTH - 2; i++) begin
      post(32'hD000_0000 + 32'(i), 0); wait_idle();
    end
    check(!q_full, "R11 one slot left, not full", {31'b0, q_full}, 32'h0);
    inc_on_ack = 1;
    post(32'hC000_0002, 0); wait_idle();
    check_ptrs("R11 same-cycle pointers");
    check(!q_full, "R11 fullness on updated tail", {31'b0, q_full}, 32'h0);
    check(exp_q.size() == 0, "R1 all posted words stored", 32'(exp_q.size()), 32'h0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog expired", 32'h0, 32'h1);
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule